// File: doc/BRIEF.md
# Mirrored Discrepancy Detector

This block compares two N-bit result words produced by two functionally identical but physically separate implementations of the same function. It reduces the comparison to a single registered match flag, which is high only when the two words agree and both checking paths are healthy. A single-cycle discrepancy pulse is also produced for downstream fitness-scoring logic.

The comparison runs on two redundant equality paths. Each path's verdict enables its own bus driver. The value that driver places on the bus is the verdict of the opposite path. The shared match bus is resolved as a wired-AND with a pull-down: an undriven bus reads 0. Because of this, a comparator stuck at "disagree" disables its own driver while its partner drives 0, so no single comparator fault can produce a false match.

Each path has a stuck-at-disagree fault-injection input. A bench uses these to walk the full fault-coverage table.

Top module: `mdd_detector`

## Requirements
- R1: While rst_ni is low, and on the first clock after its release with no rising edge yet seen, match_o and disc_pulse_o are 0.
- R2: When fn_a_i equals fn_b_i on every bit and neither stuck input is set, match_o is 1 after the next rising clock edge.
- R3: When fn_a_i and fn_b_i differ in any bit position, including only the lowest or only the highest bit, match_o is 0 after the next rising edge, whatever the stuck inputs are.
- R4: With stuck_a_i set and stuck_b_i clear, match_o is 0 after the next rising edge even for equal words. Path A's driver is disabled and path B drives 0.
- R5: With stuck_b_i set and stuck_a_i clear, match_o is 0 after the next rising edge even for equal words.
- R6: When no path drives the bus (both paths report disagree), the bus resolves to 0 and match_o is 0 after the next rising edge.
- R7: disc_pulse_o is 1 for exactly the one cycle in which match_o falls from 1 to 0. It is 0 while match_o stays 0 or stays 1, and 0 when match_o rises.
- R8: match_o reflects only the inputs present at the most recent rising edge. Inputs changed between edges have no effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fn_a_i | input | WIDTH | Result word from the first implementation |
| fn_b_i | input | WIDTH | Result word from the second implementation |
| stuck_a_i | input | 1 | Forces comparator path A to report disagree |
| stuck_b_i | input | 1 | Forces comparator path B to report disagree |
| match_o | output | 1 | Registered agreement flag |
| disc_pulse_o | output | 1 | One-cycle pulse when match_o falls |

## Verification
A data disagreement and a comparator fault injection can land in the same cycle. Both then drive the bus toward 0 through different mechanisms: one disables a driver, the other drives a low value. The vector table includes rows in which differing words coincide with one or both stuck inputs, and each such row is judged on match_o being 0. The table also places the falling edge of match_o on such rows, so the discrepancy pulse is checked in the same cycle as the combined fault.

// File: rtl/mdd_pkg.sv
package mdd_pkg;
  localparam int unsigned NPATH = 2;
  typedef logic [NPATH-1:0] path_vec_t;
endpackage

// File: rtl/mdd_cmp_path.sv
module mdd_cmp_path #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             stuck_i,
  output logic             agree_o
);
  logic [WIDTH-1:0] bit_eq;

  assign bit_eq  = ~(x_i ^ y_i);
  assign agree_o = (&bit_eq) & ~stuck_i;
endmodule

// File: rtl/mdd_bus_resolve.sv
module mdd_bus_resolve #(
  parameter int unsigned NDRV = 2
) (
  input  logic [NDRV-1:0] en_i,
  input  logic [NDRV-1:0] val_i,
  output logic            res_o
);
  logic any_en;
  logic no_low;

  // wired-AND over enabled drivers; pull-down when nobody drives
  assign any_en = |en_i;
  assign no_low = &(val_i | ~en_i);
  assign res_o  = any_en & no_low;

  always_comb begin
    if (en_i == '0) p_pull_down_r6: assert (res_o == 1'b0);
    if ((en_i & ~val_i) != '0) p_low_wins_r4: assert (res_o == 1'b0);
  end
endmodule

// File: rtl/mdd_detector.sv
module mdd_detector
  import mdd_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] fn_a_i,
  input  logic [WIDTH-1:0] fn_b_i,
  input  logic             stuck_a_i,
  input  logic             stuck_b_i,
  output logic             match_o,
  output logic             disc_pulse_o
);
  path_vec_t stuck;
  path_vec_t agree;
  path_vec_t drv_en;
  path_vec_t drv_val;
  logic      bus_match;
  logic      match_q;
  logic      pulse_q;

  assign stuck = {stuck_b_i, stuck_a_i};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam int unsigned OTHER = (p + 1) % NPATH;
    mdd_cmp_path #(.WIDTH(WIDTH)) u_path (
      .x_i     (fn_a_i),
      .y_i     (fn_b_i),
      .stuck_i (stuck[p]),
      .agree_o (agree[p])
    );
    // mirror: own verdict gates the driver, partner verdict is driven
    assign drv_en[p]  = agree[p];
    assign drv_val[p] = agree[OTHER];
  end

  mdd_bus_resolve #(.NDRV(NPATH)) u_bus (
    .en_i  (drv_en),
    .val_i (drv_val),
    .res_o (bus_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      match_q <= bus_match;
      pulse_q <= match_q & ~bus_match;
    end
  end

  assign match_o      = match_q;
  assign disc_pulse_o = pulse_q;

  p_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_a_i == fn_b_i && !stuck_a_i && !stuck_b_i) |=> match_o);
  p_differ_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_a_i != fn_b_i) |=> !match_o);
  p_stuck_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_a_i |=> !match_o);
  p_stuck_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_b_i |=> !match_o);
  p_pulse_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_pulse_o |-> (!match_o && $past(match_o)));
  p_fall_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(match_o) |-> disc_pulse_o);
endmodule

// File: tb/sim_mdd_detector.sv
`timescale 1ns/1ps
module sim_mdd_detector;
  localparam int unsigned W  = 8;
  localparam int unsigned NV = 14;
  // {a, b, stuck_a, stuck_b, expected match}
  localparam logic [2*W+2:0] VEC [NV] = '{
    {8'h5A, 8'h5A, 1'b0, 1'b0, 1'b1},
    {8'h5A, 8'h5B, 1'b0, 1'b0, 1'b0},
    {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1},
    {8'h7F, 8'hFF, 1'b0, 1'b0, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
    {8'hA5, 8'hA5, 1'b0, 1'b1, 1'b0},
    {8'hA5, 8'hA5, 1'b1, 1'b1, 1'b0},
    {8'h3C, 8'h3C, 1'b0, 1'b0, 1'b1},
    {8'h3C, 8'h3D, 1'b1, 1'b0, 1'b0},
    {8'h3C, 8'hC3, 1'b1, 1'b1, 1'b0},
    {8'h81, 8'h81, 1'b0, 1'b0, 1'b1},
    {8'h81, 8'h80, 1'b0, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] fa = '0, fb = '0;
  logic         sa = 1'b0, sb = 1'b0;
  logic         match, pulse;
  int           n_chk = 0, n_bad = 0;
  logic         prev_m = 1'b0;

  always #2 clk = ~clk;

  mdd_detector #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fn_a_i(fa), .fn_b_i(fb),
    .stuck_a_i(sa), .stuck_b_i(sb), .match_o(match), .disc_pulse_o(pulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s0, input logic s1);
    @(negedge clk);
    fa = a; fb = b; sa = s0; sb = s1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    check("R1 match in reset", match, 1'b0);
    check("R1 pulse in reset", pulse, 1'b0);
    fa = 8'h11; fb = 8'h11;
    repeat (3) @(posedge clk);
    #1;
    check("R1 match held in reset", match, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 match after release", match, 1'b0);
    check("R1 pulse after release", pulse, 1'b0);
    prev_m = 1'b0;

    // table walk: R2..R7
    for (int i = 0; i < NV; i++) begin
      logic exp_m;
      exp_m = VEC[i][0];
      apply(VEC[i][2*W+2:W+3], VEC[i][W+2:3], VEC[i][2], VEC[i][1]);
      check($sformatf("R2/R3/R4/R5/R6 row %0d match", i), match, exp_m);
      check($sformatf("R7 row %0d pulse", i), pulse, prev_m & ~exp_m);
      prev_m = exp_m;
    end

    // R7: staying low gives no further pulse
    apply(8'h01, 8'h02, 1'b0, 1'b0);
    check("R7 no pulse while low", pulse, 1'b0);
    // R7: rise gives no pulse
    apply(8'h44, 8'h44, 1'b0, 1'b0);
    check("R7 rise match", match, 1'b1);
    check("R7 no pulse on rise", pulse, 1'b0);
    apply(8'h44, 8'h44, 1'b0, 1'b0);
    check("R7 no pulse while high", pulse, 1'b0);

    // R8: glitch between edges has no effect
    @(negedge clk);
    fa = 8'h45;
    #0.5;
    fa = 8'h44;
    @(posedge clk);
    #1;
    check("R8 mid-cycle glitch ignored", match, 1'b1);
    // R8: change lands only after the edge
    @(negedge clk);
    sb = 1'b1;
    #0.5;
    check("R8 before edge", match, 1'b1);
    @(posedge clk);
    #1;
    check("R8 after edge R5", match, 1'b0);
    check("R7 pulse on stuck fall", pulse, 1'b1);

    // R6: both stuck with differing words
    apply(8'hF0, 8'h0F, 1'b1, 1'b1);
    check("R6 no driver low", match, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule